// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and a calendar date in packed binary-coded decimal. A 32.768 kHz clock enable enters a divider. Each time the divider completes a full second it emits a one-cycle tick. On that tick, seconds, minutes, hours, day of week, day of month, month and a two-digit year advance. Every carry resolves in the same clock cycle. The day of month wraps according to the current month, and February gains a 29th day in years divisible by four. A century flag can be set to invert when the year passes from 99 to 00.

Software, or a neighbouring bus block, writes any of the seven registers through a single-cycle load port. Bit 7 of the seconds register is a stop control that freezes the divider and every counter. Bit 6 of the hours register enables century toggling, and bit 7 of the hours register is the century flag itself. The current contents of all seven registers are always visible on the outputs.

Top module: `bcd_calendar_top`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (century enable 0, century flag 0), day of week 01, date 01, month 01 and year 00, and the stop bit reads 0.
- R2: The seconds register advances on the clock edge that samples the DIV-th asserted `osc_en` since the divider was last cleared. Cycles with `osc_en` low do not count toward the second.
- R3: Seconds (bits 6:0) and minutes count in BCD from 00 to 59. Reaching 59 and then ticking gives 00 and carries into the next field.
- R4: Hours (bits 5:0) count in BCD from 00 to 23. A carry out of 23 returns the hours to 00 and starts a new day.
- R5: On each new day, day of week (bits 2:0) advances from 1 to 7 and wraps from 7 back to 1.
- R6: On each new day the date advances. Past 30 in April, June, September or November, past 31 in the other months, and past 28 in February, the date returns to 01 and the month advances. The exception is February in a year whose two-digit value is divisible by 4: there the date reaches 29 first.
- R7: The month counts in BCD from 01 to 12 and wraps to 01. That wrap advances the BCD year, and the year wraps from 99 to 00.
- R8: On the year wrap, the century flag (hours bit 7) inverts only when the century enable (hours bit 6) is 1. With the enable at 0, the flag keeps its value.
- R9: While the stop bit (seconds bit 7) is 1, no register changes except through the load port, whatever `osc_en` does.
- R10: A load of the seconds register clears the divider, so the next tick needs DIV fresh enables. Loads of other registers leave the divider phase unchanged.
- R11: `wr_addr` selects 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A load at address 7 changes nothing. A tick that falls in a load cycle is dropped, and the divider still restarts its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle strobe per 32.768 kHz period |
| wr_en | input | 1 | Load strobe |
| wr_addr | input | 3 | Register selected for loading |
| wr_data | input | 8 | Value to load |
| sec_q | output | 8 | Stop bit and BCD seconds |
| min_q | output | 8 | BCD minutes |
| hour_q | output | 8 | Century flag, century enable, BCD hours |
| dow_q | output | 8 | Day of week |
| date_q | output | 8 | BCD day of month |
| month_q | output | 8 | BCD month |
| year_q | output | 8 | BCD two-digit year |

## Verification
The hardest state to reach is the full carry chain on the last second of a year, together with a February end in leap and non-leap years. Counting there through the ports would take tens of millions of ticks. The stimulus loads every field to one second before the boundary and writes the seconds register last, which puts the divider at a known phase. It then gives exactly DIV enables so that the single tick lands on a predictable edge. A dropped tick during a load is forced the same way: the bench parks the divider one enable short of a tick and issues a load in that cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned NFIELD = 7;

  typedef enum logic [2:0] {
    A_SEC   = 3'd0,
    A_MIN   = 3'd1,
    A_HOUR  = 3'd2,
    A_DOW   = 3'd3,
    A_DATE  = 3'd4,
    A_MONTH = 3'd5,
    A_YEAR  = 3'd6,
    A_NONE  = 3'd7
  } cal_addr_e;

  // Next value of a two-digit BCD number (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = v[7:4] + 4'd1;
    end else begin
      r[3:0] = v[3:0] + 4'd1;
      r[7:4] = v[7:4];
    end
    return r;
  endfunction

  // Two-digit BCD year divisible by 4: 10*t+u = 0 mod 4 <=> 2t+u = 0 mod 4.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4] == 1'b0)
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else
      return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  // Last valid date (BCD) of BCD month m in BCD year y.
  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input int i);
    case (i)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // Value a field wraps to, also its reset value.
  function automatic logic [7:0] field_lo(input int i);
    case (i)
      3, 4, 5: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_top(input int i);
    case (i)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      3:       return 8'h07;
      4:       return 8'h31;
      5:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned DIV = 32768,
  parameter int unsigned CW  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_en,
  input  logic          halt,
  input  logic          clr,
  output logic          tick,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick  = osc_en && !halt && (cnt == LAST);
  assign cnt_o = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (osc_en && !halt)  cnt <= tick ? '0 : cnt + CW'(1);
  end

endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
  parameter logic [7:0] MASK = 8'hFF,
  parameter logic [7:0] LO   = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       step,
  input  logic [7:0] top_val,
  output logic [7:0] q,
  output logic       at_top
);

  assign at_top = (q >= top_val);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= LO;
    else if (load)  q <= load_val & MASK;
    else if (step)  q <= at_top ? LO : (cal_pkg::bcd_inc(q) & MASK);
  end

endmodule

// File: rtl/cal_century.sv
module cal_century (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_en,
  input  logic load_flag,
  input  logic year_carry,
  output logic cen_q,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cen_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (load) begin
      cen_q  <= load_en;
      flag_q <= load_flag;
    end else if (year_carry && cen_q) begin
      flag_q <= ~flag_q;
    end
  end

endmodule

// File: rtl/bcd_calendar_top.sv
module bcd_calendar_top #(
  parameter int unsigned DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] dow_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q
);

  import cal_pkg::*;

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [7:0]    fld     [NFIELD];
  logic [7:0]    fld_top [NFIELD];
  logic [NFIELD-1:0] ld, fstep, hit;

  logic          stop_q, cen_q, cb_q;
  logic          tick_raw, tick_adv;
  logic          day_carry, dow_wrap, year_carry;
  logic [CW-1:0] pre_cnt;

  // load decode
  for (genvar i = 0; i < NFIELD; i++) begin : g_ld
    assign ld[i] = wr_en && (wr_addr == 3'(i));
  end

  // stop bit lives beside the seconds digits
  always_ff @(posedge clk) begin
    if (!rst_n)      stop_q <= 1'b0;
    else if (ld[0])  stop_q <= wr_data[7];
  end

  cal_prescaler #(.DIV(DIV), .CW(CW)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .halt   (stop_q),
    .clr    (ld[0]),
    .tick   (tick_raw),
    .cnt_o  (pre_cnt)
  );

  // a load cycle swallows a coincident tick
  assign tick_adv = tick_raw && !wr_en;

  // limits: fixed except the date, which follows month and year
  always_comb begin
    for (int i = 0; i < NFIELD; i++) fld_top[i] = field_top(i);
    fld_top[4] = month_len(fld[5], fld[6]);
  end

  // carry chain, all resolved in the tick cycle
  always_comb begin
    fstep[0]   = tick_adv;
    fstep[1]   = fstep[0] & hit[0];
    fstep[2]   = fstep[1] & hit[1];
    day_carry  = fstep[2] & hit[2];
    fstep[3]   = day_carry;
    fstep[4]   = day_carry;
    fstep[5]   = day_carry & hit[4];
    fstep[6]   = fstep[5] & hit[5];
    year_carry = fstep[6] & hit[6];
    dow_wrap   = day_carry & hit[3];
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    cal_bcd_field #(
      .MASK (field_mask(i)),
      .LO   (field_lo(i))
    ) u_f (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld[i]),
      .load_val (wr_data),
      .step     (fstep[i]),
      .top_val  (fld_top[i]),
      .q        (fld[i]),
      .at_top   (hit[i])
    );
  end

  cal_century u_cent (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ld[2]),
    .load_en    (wr_data[6]),
    .load_flag  (wr_data[7]),
    .year_carry (year_carry),
    .cen_q      (cen_q),
    .flag_q     (cb_q)
  );

  assign sec_q   = {stop_q, 7'b0} | fld[0];
  assign min_q   = fld[1];
  assign hour_q  = {cb_q, cen_q, 6'b0} | fld[2];
  assign dow_q   = fld[3];
  assign date_q  = fld[4];
  assign month_q = fld[5];
  assign year_q  = fld[6];

endmodule

// File: rtl/cal_checker_sva.sv
module cal_checker_sva #(
  parameter int unsigned CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_en,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic          stop_q,
  input logic          cen_q,
  input logic          cb_q,
  input logic          tick_raw,
  input logic          tick_adv,
  input logic          day_carry,
  input logic          dow_wrap,
  input logic          year_carry,
  input logic [CW-1:0] pre_cnt,
  input logic [7:0]    sec_q,
  input logic [7:0]    min_q,
  input logic [7:0]    hour_q,
  input logic [7:0]    dow_q,
  input logic [7:0]    date_q,
  input logic [7:0]    month_q,
  input logic [7:0]    year_q
);

  logic [55:0] all_regs;
  assign all_regs = {sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q};

  p_tick_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_raw |-> (osc_en && !stop_q));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_adv && sec_q[6:0] == 7'h59) |=> (sec_q[6:0] == 7'h00));

  p_day_hour_r4: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> (hour_q[5:0] == 6'h00));

  p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dow_wrap && dow_q == 8'h07) |=> (dow_q == 8'h01));

  p_year_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    year_carry |=> (year_q == 8'h00 && month_q == 8'h01 && date_q == 8'h01));

  p_cen_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cen_q) |=> $stable(cb_q));

  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> $stable(all_regs));

  p_sec_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (pre_cnt == '0));

  p_spare_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd7) |=> $stable(all_regs));

  p_drop_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_raw && wr_en && wr_addr != 3'd0) |=> $stable(sec_q));

endmodule

bind bcd_calendar_top cal_checker_sva #(.CW(CW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_en     (osc_en),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .stop_q     (stop_q),
  .cen_q      (cen_q),
  .cb_q       (cb_q),
  .tick_raw   (tick_raw),
  .tick_adv   (tick_adv),
  .day_carry  (day_carry),
  .dow_wrap   (dow_wrap),
  .year_carry (year_carry),
  .pre_cnt    (pre_cnt),
  .sec_q      (sec_q),
  .min_q      (min_q),
  .hour_q     (hour_q),
  .dow_q      (dow_q),
  .date_q     (date_q),
  .month_q    (month_q),
  .year_q     (year_q)
);

// File: tb/sim_bcd_calendar_top.sv
`timescale 1ns/1ps
module sim_bcd_calendar_top;

  localparam int unsigned DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar_top #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .dow_q(dow_q),
    .date_q(date_q), .month_q(month_q), .year_q(year_q)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic en(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      osc_en = 1'b1;
    end
    @(negedge clk);
    osc_en = 1'b0;
  endtask

  task automatic en_gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); osc_en = 1'b1;
      @(negedge clk); osc_en = 1'b0;
      @(negedge clk);
    end
  endtask

  // load everything one second before a day boundary; seconds written last
  task automatic preset(input logic [7:0] hr, input logic [7:0] dw, input logic [7:0] dt,
                        input logic [7:0] mo, input logic [7:0] yr);
    wr(3'd1, 8'h59); wr(3'd2, hr); wr(3'd3, dw);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
    wr(3'd0, 8'h59);
  endtask

  task automatic t_reset();
    chk("R1 sec", sec_q, 8'h00);   chk("R1 min", min_q, 8'h00);
    chk("R1 hour", hour_q, 8'h00); chk("R1 dow", dow_q, 8'h01);
    chk("R1 date", date_q, 8'h01); chk("R1 month", month_q, 8'h01);
    chk("R1 year", year_q, 8'h00);
  endtask

  task automatic t_tick_timing();
    wr(3'd0, 8'h09);
    en(DIV - 1);
    chk("R2 before tick", sec_q, 8'h09);
    en(1);
    chk("R2 R3 tick 09->10", sec_q, 8'h10);
    en_gap(DIV - 1);
    chk("R2 gapped before", sec_q, 8'h10);
    en_gap(1);
    chk("R2 gapped tick", sec_q, 8'h11);
  endtask

  task automatic t_minute_carry();
    wr(3'd1, 8'h37); wr(3'd0, 8'h59);
    en(DIV);
    chk("R3 sec wrap", sec_q, 8'h00);
    chk("R3 min carry", min_q, 8'h38);
  endtask

  task automatic t_day_carry();
    preset(8'h23, 8'h07, 8'h10, 8'h03, 8'h21);
    en(DIV);
    chk("R4 hour wrap", hour_q, 8'h00);
    chk("R3 min wrap", min_q, 8'h00);
    chk("R5 dow 7->1", dow_q, 8'h01);
    chk("R6 date inc", date_q, 8'h11);
    preset(8'h09, 8'h03, 8'h10, 8'h03, 8'h21);
    en(DIV);
    chk("R4 hour 09->10", hour_q, 8'h10);
    chk("R5 dow hold", dow_q, 8'h03);
    preset(8'h23, 8'h03, 8'h10, 8'h03, 8'h21);
    en(DIV);
    chk("R5 dow 3->4", dow_q, 8'h04);
  endtask

  task automatic roll_day(input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
    int mi, yi, di, last, ed, em;
    mi = b2i(mo); yi = b2i(yr); di = b2i(dt);
    if (mi == 2) last = (yi % 4 == 0) ? 29 : 28;
    else if (mi == 4 || mi == 6 || mi == 9 || mi == 11) last = 30;
    else last = 31;
    if (di == last) begin ed = 1; em = (mi == 12) ? 1 : mi + 1; end
    else begin ed = di + 1; em = mi; end
    preset(8'h23, 8'h02, dt, mo, yr);
    en(DIV);
    chk("R6 date", date_q, i2b(ed));
    chk("R6 month", month_q, i2b(em));
  endtask

  task automatic t_month_len();
    roll_day(8'h30, 8'h04, 8'h21);
    roll_day(8'h30, 8'h01, 8'h21);
    roll_day(8'h31, 8'h01, 8'h21);
    roll_day(8'h28, 8'h02, 8'h23);
    roll_day(8'h28, 8'h02, 8'h24);
    roll_day(8'h29, 8'h02, 8'h24);
    roll_day(8'h28, 8'h02, 8'h12);
    roll_day(8'h28, 8'h02, 8'h00);
    roll_day(8'h30, 8'h11, 8'h05);
  endtask

  task automatic t_year_century();
    preset(8'h63, 8'h04, 8'h31, 8'h12, 8'h99);
    en(DIV);
    chk("R7 year wrap", year_q, 8'h00);
    chk("R7 month wrap", month_q, 8'h01);
    chk("R8 flag 0->1", hour_q, 8'hC0);
    preset(8'hE3, 8'h04, 8'h31, 8'h12, 8'h99);
    en(DIV);
    chk("R8 flag 1->0", hour_q, 8'h40);
    preset(8'hA3, 8'h04, 8'h31, 8'h12, 8'h99);
    en(DIV);
    chk("R8 disabled holds", hour_q, 8'h80);
    preset(8'h23, 8'h04, 8'h31, 8'h12, 8'h41);
    en(DIV);
    chk("R7 year 41->42", year_q, 8'h42);
  endtask

  task automatic t_stop();
    wr(3'd1, 8'h10);
    wr(3'd0, 8'hA5);
    en(DIV * 3);
    chk("R9 sec frozen", sec_q, 8'hA5);
    chk("R9 min frozen", min_q, 8'h10);
    wr(3'd0, 8'h25);
    en(DIV - 1);
    chk("R9 resume before", sec_q, 8'h25);
    en(1);
    chk("R9 resume tick", sec_q, 8'h26);
  endtask

  task automatic t_divider_clear();
    wr(3'd0, 8'h40);
    en(5);
    wr(3'd0, 8'h40);
    en(DIV - 1);
    chk("R10 cleared no tick", sec_q, 8'h40);
    en(1);
    chk("R10 full second", sec_q, 8'h41);
    en(5);
    wr(3'd1, 8'h22);
    en(DIV - 6);
    chk("R10 min load before", sec_q, 8'h41);
    en(1);
    chk("R10 min load keeps phase", sec_q, 8'h42);
  endtask

  task automatic t_addr_collide();
    logic [55:0] snap;
    snap = {sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q};
    wr(3'd7, 8'hFF);
    chk("R11 spare addr hi", 8'({sec_q, min_q, hour_q, dow_q} ^ snap[55:24]), 8'h00);
    chk("R11 spare addr lo", 8'({date_q, month_q, year_q} ^ snap[23:0]), 8'h00);
    chk("R11 spare sec", sec_q, snap[55:48]);
    chk("R11 spare year", year_q, snap[7:0]);
    wr(3'd0, 8'h00);
    en(DIV - 1);
    @(negedge clk);
    osc_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
    @(negedge clk);
    osc_en = 1'b0; wr_en = 1'b0;
    chk("R11 tick dropped", sec_q, 8'h00);
    chk("R11 min loaded", min_q, 8'h33);
    en(DIV);
    chk("R11 divider restarted", sec_q, 8'h01);
  endtask

  initial begin
    #500000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick_timing();
    t_minute_carry();
    t_day_carry();
    t_month_len();
    t_year_century();
    t_stop();
    t_divider_clear();
    t_addr_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule